// File: doc/BRIEF.md
# Memory-Mapped Arithmetic Coprocessor

This block is a small coprocessor that sits on a simple parallel host bus. The bus carries a byte of data and a 4-bit address, with a single-cycle write strobe and a single-cycle read strobe. The host writes argument bytes to three argument addresses. It then reads three derived results:

- the increment argument plus one;
- the number of set bits in the population-count argument;
- the largest value written to the maximum address since reset.

All three results are computed from the stored registers. A result read is therefore correct on any cycle after the matching write, however the host spaces its accesses. Read data is combinational from the address while the read strobe is high, and is zero otherwise. The data width and the address map are parameters. A generate option selects how the bit counter is built.

Top module: `arith_coproc`

## Requirements
- R1: A write to address 0x1 stores the increment argument. A read from address 0x2 returns that argument plus one, modulo 256, so 0xFF reads back as 0x00.
- R2: A write to address 0x3 stores a byte. A read from address 0x4 returns the count of 1 bits in that byte, zero-extended to 8 bits, in the range 0 to 8.
- R3: A read from address 0x6 returns the largest unsigned value written to address 0x5 since reset, or 0x00 if nothing has been written there.
- R4: Reads from addresses 0x1, 0x3 and 0x5 return the value most recently written to that address.
- R5: Writes to addresses 0x2, 0x4 and 0x6 change no stored state.
- R6: Writes to addresses 0x0 and 0x7 to 0xF change no stored state, and reads from those addresses return 0x00.
- R7: After reset, every argument register and the running maximum hold 0x00, so reads of 0x1 to 0x6 give 0x00, 0x01, 0x00, 0x00, 0x00, 0x00.
- R8: `rdata` is 0x00 whenever `rd_en` is low.
- R9: A write takes effect on the rising clock edge where `wr_en` is high. A read in the following cycle, or any later cycle, returns the updated result with no wait cycles, whatever the gaps between accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address for the current access |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; enables read data |
| rdata | output | 8 | Read data, combinational from the address |

## Verification
Increment arguments include an ordinary value and 0xFF. Together they separate a correct modulo-256 wrap from a carry that leaks or saturates.

Population-count arguments of 0x00, 0xFF and a mixed byte cover both ends of the count range. The mixed byte also exposes any bit ordering or truncation fault.

Maximum writes include a descending value and a value above 0x7F. These tell a true running maximum from a last-written register, and unsigned comparison from signed comparison.

A long pseudo-random mix of writes, reads and idle gaps across all sixteen addresses is checked against a model of the register map. This sequence catches stray writes through result or unmapped addresses, and results that lag behind their arguments.

// File: rtl/arith_coproc_pkg.sv
package arith_coproc_pkg;

   typedef enum logic [2:0] {
      SEL_NONE    = 3'd0,
      SEL_INC_ARG = 3'd1,
      SEL_INC_RES = 3'd2,
      SEL_POP_ARG = 3'd3,
      SEL_POP_RES = 3'd4,
      SEL_MAX_ARG = 3'd5,
      SEL_MAX_RES = 3'd6
   } rd_sel_t;

   localparam int unsigned DEF_ADDR_W    = 4;
   localparam int unsigned DEF_DATA_W    = 8;
   localparam int unsigned DEF_A_INC_ARG = 1;
   localparam int unsigned DEF_A_INC_RES = 2;
   localparam int unsigned DEF_A_POP_ARG = 3;
   localparam int unsigned DEF_A_POP_RES = 4;
   localparam int unsigned DEF_A_MAX_ARG = 5;
   localparam int unsigned DEF_A_MAX_RES = 6;

endpackage

// File: rtl/cp_decode.sv
module cp_decode
   import arith_coproc_pkg::*;
#(
   parameter int unsigned ADDR_W    = DEF_ADDR_W,
   parameter int unsigned A_INC_ARG = DEF_A_INC_ARG,
   parameter int unsigned A_INC_RES = DEF_A_INC_RES,
   parameter int unsigned A_POP_ARG = DEF_A_POP_ARG,
   parameter int unsigned A_POP_RES = DEF_A_POP_RES,
   parameter int unsigned A_MAX_ARG = DEF_A_MAX_ARG,
   parameter int unsigned A_MAX_RES = DEF_A_MAX_RES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   output logic              we_inc,
   output logic              we_pop,
   output logic              we_max,
   output rd_sel_t           rd_sel
);

   localparam logic [ADDR_W-1:0] AI = ADDR_W'(A_INC_ARG);
   localparam logic [ADDR_W-1:0] AJ = ADDR_W'(A_INC_RES);
   localparam logic [ADDR_W-1:0] AP = ADDR_W'(A_POP_ARG);
   localparam logic [ADDR_W-1:0] AQ = ADDR_W'(A_POP_RES);
   localparam logic [ADDR_W-1:0] AM = ADDR_W'(A_MAX_ARG);
   localparam logic [ADDR_W-1:0] AN = ADDR_W'(A_MAX_RES);

   if (A_INC_ARG >= (1 << ADDR_W) || A_MAX_RES >= (1 << ADDR_W)) begin : g_bad_range
      $error("cp_decode: an address does not fit in ADDR_W bits");
   end
   if (A_INC_ARG == A_POP_ARG || A_POP_ARG == A_MAX_ARG || A_INC_ARG == A_MAX_ARG ||
       A_INC_RES == A_POP_RES || A_POP_RES == A_MAX_RES || A_INC_RES == A_MAX_RES) begin : g_bad_map
      $error("cp_decode: argument or result addresses collide");
   end

   always_comb begin
      we_inc = wr_en && (addr == AI);
      we_pop = wr_en && (addr == AP);
      we_max = wr_en && (addr == AM);
   end

   always_comb begin
      if      (addr == AI) rd_sel = SEL_INC_ARG;
      else if (addr == AJ) rd_sel = SEL_INC_RES;
      else if (addr == AP) rd_sel = SEL_POP_ARG;
      else if (addr == AQ) rd_sel = SEL_POP_RES;
      else if (addr == AM) rd_sel = SEL_MAX_ARG;
      else if (addr == AN) rd_sel = SEL_MAX_RES;
      else                 rd_sel = SEL_NONE;
   end

   // at most one argument register is written per access (supports R5, R6)
   assert_we_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({we_inc, we_pop, we_max}));

   // no write enable without the host strobe (R6)
   assert_we_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> !(we_inc || we_pop || we_max));

endmodule

// File: rtl/cp_argreg.sv
module cp_argreg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end

   // an unloaded register keeps its value (R5, R6)
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

   // a loaded register shows the written byte on the next cycle (R9)
   assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(din)));

endmodule

// File: rtl/cp_maxtrack.sv
module cp_maxtrack #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              offer,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] peak
);

   logic take;

   always_comb take = offer && (din > peak);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    peak <= '0;
      else if (take) peak <= din;
   end

   // the running maximum never decreases (R3)
   assert_max_mono_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (peak >= $past(peak)));

   // after an offer the maximum is at least the offered value (R3)
   assert_max_covers_R3: assert property (@(posedge clk) disable iff (!rst_n)
      offer |=> (peak >= $past(din)));

   // without an offer nothing moves (R5, R6)
   assert_max_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !offer |=> $stable(peak));

endmodule

// File: rtl/cp_popcount.sv
module cp_popcount #(
   parameter int unsigned W     = 8,
   parameter bit          NIBBLE = 1'b1,
   localparam int unsigned CNT_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     din,
   output logic [CNT_W-1:0] cnt
);

   if (NIBBLE) begin : g_nibble
      localparam int unsigned NCH = (W + 3) / 4;
      localparam int unsigned PW  = NCH * 4;
      logic [PW-1:0] padded;
      logic [2:0]    part [NCH];

      always_comb padded = PW'(din);

      for (genvar c = 0; c < NCH; c++) begin : g_chunk
         always_comb
            part[c] = 3'(padded[4*c]) + 3'(padded[4*c+1]) +
                      3'(padded[4*c+2]) + 3'(padded[4*c+3]);
      end

      always_comb begin
         cnt = '0;
         for (int c = 0; c < NCH; c++) cnt = cnt + CNT_W'(part[c]);
      end
   end else begin : g_serial
      always_comb begin
         cnt = '0;
         for (int b = 0; b < W; b++) cnt = cnt + CNT_W'(din[b]);
      end
   end

   // the count equals the number of set bits (R2)
   always_comb assert_popcount_R2: assert (cnt == CNT_W'($countones(din)));

endmodule

// File: rtl/arith_coproc.sv
module arith_coproc
   import arith_coproc_pkg::*;
#(
   parameter int unsigned ADDR_W      = DEF_ADDR_W,
   parameter int unsigned DATA_W      = DEF_DATA_W,
   parameter int unsigned A_INC_ARG   = DEF_A_INC_ARG,
   parameter int unsigned A_INC_RES   = DEF_A_INC_RES,
   parameter int unsigned A_POP_ARG   = DEF_A_POP_ARG,
   parameter int unsigned A_POP_RES   = DEF_A_POP_RES,
   parameter int unsigned A_MAX_ARG   = DEF_A_MAX_ARG,
   parameter int unsigned A_MAX_RES   = DEF_A_MAX_RES,
   parameter bit          POP_NIBBLE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned CNT_W = $clog2(DATA_W + 1);

   if (DATA_W < 4) begin : g_bad_width
      $error("arith_coproc: DATA_W must be at least 4");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("arith_coproc: ADDR_W must be at least 3");
   end

   logic              we_inc, we_pop, we_max;
   rd_sel_t           rd_sel;
   logic [DATA_W-1:0] inc_arg, pop_arg, max_arg, max_peak, inc_res;
   logic [CNT_W-1:0]  pop_cnt;

   cp_decode #(
      .ADDR_W(ADDR_W),
      .A_INC_ARG(A_INC_ARG), .A_INC_RES(A_INC_RES),
      .A_POP_ARG(A_POP_ARG), .A_POP_RES(A_POP_RES),
      .A_MAX_ARG(A_MAX_ARG), .A_MAX_RES(A_MAX_RES)
   ) i_decode (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .we_inc(we_inc), .we_pop(we_pop), .we_max(we_max), .rd_sel(rd_sel)
   );

   cp_argreg #(.DATA_W(DATA_W)) i_inc_arg (
      .clk(clk), .rst_n(rst_n), .load(we_inc), .din(wdata), .q(inc_arg));

   cp_argreg #(.DATA_W(DATA_W)) i_pop_arg (
      .clk(clk), .rst_n(rst_n), .load(we_pop), .din(wdata), .q(pop_arg));

   cp_argreg #(.DATA_W(DATA_W)) i_max_arg (
      .clk(clk), .rst_n(rst_n), .load(we_max), .din(wdata), .q(max_arg));

   cp_maxtrack #(.DATA_W(DATA_W)) i_maxtrack (
      .clk(clk), .rst_n(rst_n), .offer(we_max), .din(wdata), .peak(max_peak));

   cp_popcount #(.W(DATA_W), .NIBBLE(POP_NIBBLE)) i_popcount (
      .din(pop_arg), .cnt(pop_cnt));

   always_comb inc_res = inc_arg + DATA_W'(1);

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (rd_sel)
            SEL_INC_ARG: rdata = inc_arg;
            SEL_INC_RES: rdata = inc_res;
            SEL_POP_ARG: rdata = pop_arg;
            SEL_POP_RES: rdata = {{(DATA_W-CNT_W){1'b0}}, pop_cnt};
            SEL_MAX_ARG: rdata = max_arg;
            SEL_MAX_RES: rdata = max_peak;
            default:     rdata = '0;
         endcase
      end
   end

   // idle bus drives zero (R8)
   assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rdata == '0));

   // writes outside the argument addresses leave every register alone (R5, R6)
   assert_stray_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(we_inc || we_pop || we_max)) |=>
         ($stable(inc_arg) && $stable(pop_arg) && $stable(max_arg) && $stable(max_peak)));

   // an increment read right after its write shows the new argument plus one (R1, R9)
   assert_inc_fresh_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (we_inc && !$past(!rst_n)) |=> ((rd_sel != SEL_INC_RES) || !rd_en ||
                                       (rdata == $past(wdata) + DATA_W'(1))));

endmodule

// File: tb/test_arith_coproc.sv
module test_arith_coproc;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   arith_coproc i_arith_coproc (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata));

   always #2 clk = ~clk;

   // vector: {is_write, addr, data, expected_read, requirement}
   localparam int NV = 24;
   localparam logic [24:0] VEC [NV] = '{
      {1'b1, 4'h1, 8'h41, 8'h00, 4'd1},
      {1'b0, 4'h2, 8'h00, 8'h42, 4'd1},   // R1 plain increment
      {1'b0, 4'h1, 8'h00, 8'h41, 4'd4},   // R4 read back
      {1'b1, 4'h1, 8'hFF, 8'h00, 4'd1},
      {1'b0, 4'h2, 8'h00, 8'h00, 4'd1},   // R1 wrap
      {1'b1, 4'h3, 8'hB5, 8'h00, 4'd2},
      {1'b0, 4'h4, 8'h00, 8'h05, 4'd2},   // R2 mixed byte
      {1'b0, 4'h3, 8'h00, 8'hB5, 4'd4},
      {1'b1, 4'h3, 8'hFF, 8'h00, 4'd2},
      {1'b0, 4'h4, 8'h00, 8'h08, 4'd2},   // R2 all ones
      {1'b1, 4'h3, 8'h00, 8'h00, 4'd2},
      {1'b0, 4'h4, 8'h00, 8'h00, 4'd2},   // R2 all zeros
      {1'b1, 4'h5, 8'h30, 8'h00, 4'd3},
      {1'b0, 4'h6, 8'h00, 8'h30, 4'd3},   // R3 first value
      {1'b1, 4'h5, 8'h10, 8'h00, 4'd3},
      {1'b0, 4'h6, 8'h00, 8'h30, 4'd3},   // R3 smaller ignored
      {1'b0, 4'h5, 8'h00, 8'h10, 4'd4},   // R4 last written, not max
      {1'b1, 4'h5, 8'h90, 8'h00, 4'd3},
      {1'b0, 4'h6, 8'h00, 8'h90, 4'd3},   // R3 unsigned compare
      {1'b1, 4'h2, 8'h77, 8'h00, 4'd5},
      {1'b1, 4'h4, 8'h77, 8'h00, 4'd5},
      {1'b1, 4'h6, 8'hFF, 8'h00, 4'd5},
      {1'b0, 4'h1, 8'h00, 8'hFF, 4'd5},   // R5 arg untouched
      {1'b0, 4'h6, 8'h00, 8'h90, 4'd5}    // R5 max untouched
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1; wr_en = 1'b0;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic check_reset_state(input string tag);
      logic [7:0] v;
      logic [7:0] exp6 [6] = '{8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
      for (int a = 1; a <= 6; a++) begin
         bus_read(4'(a), v);
         check(tag, v, exp6[a-1]);
      end
   endtask

   function automatic logic [7:0] model_read(input logic [3:0] a, input logic [7:0] mi,
                                             input logic [7:0] mp, input logic [7:0] ma,
                                             input logic [7:0] mx);
      case (a)
         4'h1: return mi;
         4'h2: return mi + 8'd1;
         4'h3: return mp;
         4'h4: return 8'($countones(mp));
         4'h5: return ma;
         4'h6: return mx;
         default: return 8'h00;
      endcase
   endfunction

   initial begin
      #400000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] mi, mp, ma, mx;
      logic [15:0] lfsr;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R7 reset contents, R8 idle zero
      check_reset_state("R7 reset");
      @(negedge clk); addr = 4'h2; #1 check("R8 idle", rdata, 8'h00);

      // vector table walk
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][24]) bus_write(VEC[i][23:20], VEC[i][19:12]);
         else begin
            bus_read(VEC[i][23:20], v);
            check($sformatf("R%0d vec%0d", VEC[i][3:0], i), v, VEC[i][11:4]);
         end
      end

      // R6 unmapped writes and reads
      bus_write(4'h0, 8'hAA);
      bus_write(4'h9, 8'h55);
      bus_write(4'hF, 8'hFF);
      bus_read(4'h1, v); check("R6 inc arg kept", v, 8'hFF);
      bus_read(4'h3, v); check("R6 pop arg kept", v, 8'h00);
      bus_read(4'h5, v); check("R6 max arg kept", v, 8'h90);
      bus_read(4'h6, v); check("R6 max kept", v, 8'h90);
      bus_read(4'h0, v); check("R6 read 0x0", v, 8'h00);
      bus_read(4'hC, v); check("R6 read 0xC", v, 8'h00);

      // R9 read in the cycle right after the write edge
      @(negedge clk); addr = 4'h1; wdata = 8'h7E; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; addr = 4'h2; rd_en = 1'b1;
      #1 check("R9 back-to-back inc", rdata, 8'h7F);
      @(negedge clk); addr = 4'h3; wdata = 8'h0F; wr_en = 1'b1; rd_en = 1'b0;
      @(negedge clk); wr_en = 1'b0; addr = 4'h4; rd_en = 1'b1;
      #1 check("R9 back-to-back pop", rdata, 8'h04);
      @(negedge clk); rd_en = 1'b0;

      // R7 reset in the middle of a run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check_reset_state("R7 mid-run reset");

      // R9 irregular traffic against a register-map model
      mi = 0; mp = 0; ma = 0; mx = 0;
      lfsr = 16'hACE1;
      for (int n = 0; n < 600; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (lfsr[1:0])
            2'd0, 2'd3: begin
               bus_write(lfsr[5:2], lfsr[13:6]);
               case (lfsr[5:2])
                  4'h1: mi = lfsr[13:6];
                  4'h3: mp = lfsr[13:6];
                  4'h5: begin ma = lfsr[13:6]; if (lfsr[13:6] > mx) mx = lfsr[13:6]; end
                  default: ;
               endcase
            end
            2'd1: begin
               bus_read(lfsr[5:2], v);
               check($sformatf("R9 random read addr 0x%0h", lfsr[5:2]), v,
                     model_read(lfsr[5:2], mi, mp, ma, mx));
            end
            default: repeat (int'(lfsr[4:2])) @(negedge clk);
         endcase
      end
      for (int a = 1; a <= 6; a++) begin
         bus_read(4'(a), v);
         check("R3 final map", v, model_read(4'(a), mi, mp, ma, mx));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule